// File: doc/BRIEF.md
# Translation Unit Command and Status Register Block

This block is the control face of a page-translating memory management unit. Software reaches it through a plain 32-bit word register port. Writes are taken in the cycle `reg_wr` is high. Reads are combinational from `reg_addr`. The block keeps the translation directory base, the paging and stall state, and the page-fault record. It also keeps a small interrupt cause set with raw, clear, mask and masked views.

Software drives the unit by writing single-word commands to the command register. The commands turn paging on or off, enter or leave stall, flush the whole translation cache, acknowledge a page fault and return the unit to its power-on state. Interlocks guard these commands. Stall is refused while paging is off or while a fault is outstanding. A fault holds the translating master until software acknowledges it.

The table walker sits next to the block. It receives the directory base, the paging, stall and hold controls, and the flush pulses. It returns fault, bus-error, idle and replay-empty indications.

Top module: `mmu_cmd_ctrl`

## Requirements
- R1: A write to offset 0x00 stores the data with bits [11:0] forced to zero. The directory base reads back at 0x00 and drives `xl_dir_base`, so 0xCAFEBABE reads as 0xCAFEB000.
- R2: The command register sits at offset 0x08, and the code is taken from `wdata[2:0]`. Code 0 turns paging on. Code 1 turns paging off and also drops stall. Status bit 0 and `xl_paging_en` show the new state in the cycle after the write.
- R3: Code 2 enters stall only while paging is on and no fault is active; otherwise it is ignored. Code 3 leaves stall. Status bit 2 and `xl_stall` show stall, and status bit 31 is always the inverse of bit 2.
- R4: A `wk_fault` pulse while paging is on and no fault is active does three things. It sets fault-active (status bit 1 and `xl_hold`), captures `wk_fault_addr` into offset 0x0C and captures `wk_fault_write` into status bit 5. Faults that arrive while a fault is active, or while paging is off, leave the captured record unchanged.
- R5: Code 5 clears fault-active and releases `xl_hold`. Until code 5 or code 6 is written, fault-active stays set.
- R6: Code 4 raises `xl_zap_all` for exactly one cycle. A write to offset 0x10 raises `xl_zap_line` for one cycle, with `xl_zap_line_addr` set to the written data with bits [11:0] cleared. Offset 0x10 reads as zero.
- R7: Code 6 returns every register to its power-on value in the following cycle, and it overrides all events in the same cycle. Power-on values are all zero, except for the input-mirror status bits and status bit 31.
- R8: The raw cause register at offset 0x14 has two bits. Bit 0 is set by a fault taken while paging is on. Bit 1 is set by `wk_bus_err` in any state. Both bits can be pending together.
- R9: Writing to offset 0x18 clears each raw bit whose data bit is 1. A new event on a bit in the same cycle keeps that bit set. Offset 0x18 reads as zero.
- R10: The mask register at offset 0x1C is read/write in bits [1:0]. Offset 0x20 reads raw AND mask, and `irq` is high exactly when that value is nonzero.
- R11: Status bit 3 mirrors `wk_idle` and status bit 4 mirrors `wk_replay_empty` in the same cycle.
- R12: Offset 0x24 bit 0 is read/write and drives `xl_gate_en`. The following are ignored: writes to other offsets, writes to read-only offsets, and command code 7. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| wk_fault | input | 1 | Page fault event from the walker |
| wk_fault_addr | input | DATA_W | Virtual address of the faulting access |
| wk_fault_write | input | 1 | Faulting access was a write |
| wk_bus_err | input | 1 | Bus error during a table read |
| wk_idle | input | 1 | Walker is idle |
| wk_replay_empty | input | 1 | Replay buffer is empty |
| xl_paging_en | output | 1 | Translation enabled |
| xl_stall | output | 1 | Stall the translating master |
| xl_hold | output | 1 | Fault hold, released by acknowledge |
| xl_zap_all | output | 1 | One-cycle flush of the whole translation cache |
| xl_zap_line | output | 1 | One-cycle flush of one page entry |
| xl_zap_line_addr | output | DATA_W | Page address for the single-entry flush |
| xl_dir_base | output | DATA_W | Directory base address |
| xl_gate_en | output | 1 | Automatic clock gating enable |
| irq | output | 1 | Interrupt request, masked causes ORed |

## Verification
The bench builds the block with DATA_W=32, ADDR_W=8 and PAGE_SHIFT=12. These values make the 0xCAFEBABE-to-0xCAFEB000 truncation literal and put status bit 31 at the top of the word. The 8-bit offset space leaves plenty of unmapped offsets above 0x24, which the random phase writes and reads. A behavioural model, compared on every clock, covers same-cycle collisions that directed steps rarely reach. Examples are fault against fault-done, a clear write against a new event, and hard reset against a pending fault.

// File: rtl/mmu_ctrl_pkg.sv
package mmu_ctrl_pkg;

   // register byte offsets
   localparam int OFF_DIR    = 'h00;
   localparam int OFF_STAT   = 'h04;
   localparam int OFF_CMD    = 'h08;
   localparam int OFF_FADDR  = 'h0C;
   localparam int OFF_ZLINE  = 'h10;
   localparam int OFF_RAW    = 'h14;
   localparam int OFF_CLR    = 'h18;
   localparam int OFF_MASK   = 'h1C;
   localparam int OFF_MSTAT  = 'h20;
   localparam int OFF_GATE   = 'h24;

   // command codes carried in wdata[2:0]
   typedef enum logic [2:0] {
      CMD_PG_ON     = 3'd0,
      CMD_PG_OFF    = 3'd1,
      CMD_STALL_ON  = 3'd2,
      CMD_STALL_OFF = 3'd3,
      CMD_ZAP_ALL   = 3'd4,
      CMD_FLT_DONE  = 3'd5,
      CMD_HARD_RST  = 3'd6,
      CMD_NONE      = 3'd7
   } mmu_cmd_e;

   // status bit positions (stall-not-active sits at the word MSB)
   localparam int ST_PAGING = 0;
   localparam int ST_FAULT  = 1;
   localparam int ST_STALL  = 2;
   localparam int ST_IDLE   = 3;
   localparam int ST_REPLAY = 4;
   localparam int ST_FWRITE = 5;

   // interrupt causes: bit 0 page fault, bit 1 bus error
   localparam int NUM_CAUSES = 2;
   localparam int CAUSE_PF   = 0;
   localparam int CAUSE_BUS  = 1;

endpackage

// File: rtl/mmu_cmd_core.sv
module mmu_cmd_core
   import mmu_ctrl_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int PAGE_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_we,
   input  logic              cmd_we,
   input  logic              zline_we,
   input  logic              gate_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wk_fault,
   input  logic [DATA_W-1:0] wk_fault_addr,
   input  logic              wk_fault_write,
   output logic              paging_o,
   output logic              stall_o,
   output logic              fault_o,
   output logic              fault_wr_o,
   output logic [DATA_W-1:0] fault_addr_o,
   output logic [DATA_W-1:0] dir_base_o,
   output logic              zap_all_o,
   output logic              zap_line_o,
   output logic [DATA_W-1:0] zap_line_addr_o,
   output logic              gate_o,
   output logic              flt_evt_o,
   output logic              hard_rst_o
);

   localparam int HI_W = DATA_W - PAGE_SHIFT;
   localparam logic [DATA_W-1:0] PG_MASK = {{HI_W{1'b1}}, {PAGE_SHIFT{1'b0}}};

   mmu_cmd_e code;
   logic paging_q, stall_q, fault_q, fwr_q, zap_all_q, zap_line_q, gate_q;
   logic [DATA_W-1:0] dir_q, faddr_q, zla_q;
   logic is_stall_on, is_done, is_zap;

   assign code        = mmu_cmd_e'(wdata[2:0]);
   assign hard_rst_o  = cmd_we && (code == CMD_HARD_RST);
   assign flt_evt_o   = wk_fault && paging_q;
   assign is_stall_on = cmd_we && (code == CMD_STALL_ON);
   assign is_done     = cmd_we && (code == CMD_FLT_DONE);
   assign is_zap      = cmd_we && (code == CMD_ZAP_ALL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paging_q   <= 1'b0;
         stall_q    <= 1'b0;
         fault_q    <= 1'b0;
         fwr_q      <= 1'b0;
         faddr_q    <= '0;
         dir_q      <= '0;
         zap_all_q  <= 1'b0;
         zap_line_q <= 1'b0;
         zla_q      <= '0;
         gate_q     <= 1'b0;
      end else if (hard_rst_o) begin
         paging_q   <= 1'b0;
         stall_q    <= 1'b0;
         fault_q    <= 1'b0;
         fwr_q      <= 1'b0;
         faddr_q    <= '0;
         dir_q      <= '0;
         zap_all_q  <= 1'b0;
         zap_line_q <= 1'b0;
         zla_q      <= '0;
         gate_q     <= 1'b0;
      end else begin
         zap_all_q  <= 1'b0;
         zap_line_q <= 1'b0;
         if (dir_we)  dir_q  <= wdata & PG_MASK;
         if (gate_we) gate_q <= wdata[0];
         if (zline_we) begin
            zap_line_q <= 1'b1;
            zla_q      <= wdata & PG_MASK;
         end
         if (cmd_we) begin
            case (code)
               CMD_PG_ON:     paging_q <= 1'b1;
               CMD_PG_OFF: begin
                  paging_q <= 1'b0;
                  stall_q  <= 1'b0;
               end
               CMD_STALL_ON:  if (paging_q && !fault_q) stall_q <= 1'b1;
               CMD_STALL_OFF: stall_q <= 1'b0;
               CMD_ZAP_ALL:   zap_all_q <= 1'b1;
               CMD_FLT_DONE:  fault_q <= 1'b0;
               default: ;
            endcase
         end
         if (flt_evt_o && !fault_q) begin
            fault_q <= 1'b1;
            faddr_q <= wk_fault_addr;
            fwr_q   <= wk_fault_write;
         end
      end
   end

   assign paging_o        = paging_q;
   assign stall_o         = stall_q;
   assign fault_o         = fault_q;
   assign fault_wr_o      = fwr_q;
   assign fault_addr_o    = faddr_q;
   assign dir_base_o      = dir_q;
   assign zap_all_o       = zap_all_q;
   assign zap_line_o      = zap_line_q;
   assign zap_line_addr_o = zla_q;
   assign gate_o          = gate_q;

   // R1: stored base equals written data with the page offset dropped
   p_dir_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_we && !hard_rst_o) |=> (dir_base_o == ($past(wdata) & PG_MASK)));

   // R3: stall only exists while paging is on
   p_stall_needs_paging_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> paging_o);

   // R3: stall request refused during an active fault
   p_no_stall_on_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_stall_on && fault_o && !stall_o) |=> !stall_o);

   // R5: fault holds until acknowledged or hard reset
   p_fault_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && !is_done && !hard_rst_o) |=> fault_o);

   // R4: captured address is stable while the fault is held
   p_faddr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && !hard_rst_o) |=> $stable(fault_addr_o));

   // R6: flush pulse lasts one cycle
   p_zap_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (zap_all_o && !is_zap) |=> !zap_all_o);

   // R7: hard reset clears the controlling state
   p_hard_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hard_rst_o |=> (dir_base_o == '0 && !paging_o && !stall_o && !fault_o && !gate_o));

endmodule

// File: rtl/mmu_irq_unit.sv
module mmu_irq_unit
   import mmu_ctrl_pkg::*;
#(
   parameter int NC = NUM_CAUSES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic [NC-1:0] evt,
   input  logic          clr_we,
   input  logic          mask_we,
   input  logic [NC-1:0] wbits,
   output logic [NC-1:0] raw_o,
   output logic [NC-1:0] mask_o,
   output logic [NC-1:0] masked_o,
   output logic          irq_o
);

   logic [NC-1:0] raw_q, raw_nxt, mask_q;

   for (genvar g = 0; g < NC; g++) begin : g_cause
      // a new event outranks a clear of the same bit
      assign raw_nxt[g] = evt[g] | (raw_q[g] & ~(clr_we & wbits[g]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else if (soft_rst) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else begin
         raw_q <= raw_nxt;
         if (mask_we) mask_q <= wbits;
      end
   end

   assign raw_o    = raw_q;
   assign mask_o   = mask_q;
   assign masked_o = raw_q & mask_q;
   assign irq_o    = |masked_o;

   // R9: a clear without a competing event drops the bit
   p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && wbits[0] && !evt[0] && !soft_rst) |=> !raw_o[0]);

   // R9: an event keeps the bit set even against a clear
   p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[0] && !soft_rst) |=> raw_o[0]);

   // R8: pending causes persist until cleared or reset
   p_raw_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_o[1] && !clr_we && !soft_rst) |=> raw_o[1]);

endmodule

// File: rtl/mmu_rd_mux.sv
module mmu_rd_mux
   import mmu_ctrl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     dir_base,
   input  logic                  paging,
   input  logic                  fault,
   input  logic                  stall,
   input  logic                  idle,
   input  logic                  replay_empty,
   input  logic                  fault_wr,
   input  logic [DATA_W-1:0]     fault_addr,
   input  logic [NUM_CAUSES-1:0] raw,
   input  logic [NUM_CAUSES-1:0] mask,
   input  logic [NUM_CAUSES-1:0] masked,
   input  logic                  gate,
   output logic [DATA_W-1:0]     rdata
);

   logic [DATA_W-1:0] status;

   always_comb begin
      status             = '0;
      status[ST_PAGING]  = paging;
      status[ST_FAULT]   = fault;
      status[ST_STALL]   = stall;
      status[ST_IDLE]    = idle;
      status[ST_REPLAY]  = replay_empty;
      status[ST_FWRITE]  = fault_wr;
      status[DATA_W-1]   = ~stall;
   end

   always_comb begin
      rdata = '0;
      if      (addr == ADDR_W'(OFF_DIR))   rdata = dir_base;
      else if (addr == ADDR_W'(OFF_STAT))  rdata = status;
      else if (addr == ADDR_W'(OFF_FADDR)) rdata = fault_addr;
      else if (addr == ADDR_W'(OFF_RAW))   rdata[NUM_CAUSES-1:0] = raw;
      else if (addr == ADDR_W'(OFF_MASK))  rdata[NUM_CAUSES-1:0] = mask;
      else if (addr == ADDR_W'(OFF_MSTAT)) rdata[NUM_CAUSES-1:0] = masked;
      else if (addr == ADDR_W'(OFF_GATE))  rdata[0] = gate;
   end

endmodule

// File: rtl/mmu_cmd_ctrl.sv
module mmu_cmd_ctrl
   import mmu_ctrl_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 8,
   parameter int PAGE_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              wk_fault,
   input  logic [DATA_W-1:0] wk_fault_addr,
   input  logic              wk_fault_write,
   input  logic              wk_bus_err,
   input  logic              wk_idle,
   input  logic              wk_replay_empty,
   output logic              xl_paging_en,
   output logic              xl_stall,
   output logic              xl_hold,
   output logic              xl_zap_all,
   output logic              xl_zap_line,
   output logic [DATA_W-1:0] xl_zap_line_addr,
   output logic [DATA_W-1:0] xl_dir_base,
   output logic              xl_gate_en,
   output logic              irq
);

   if (DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must be at least 8");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("ADDR_W must reach offset 0x24");
   end
   if (PAGE_SHIFT < 1 || PAGE_SHIFT >= DATA_W) begin : g_bad_page
      $error("PAGE_SHIFT must lie inside the data word");
   end

   logic dir_we, cmd_we, zline_we, gate_we, clr_we, mask_we;
   logic fault, fault_wr, flt_evt, hard_rst;
   logic [DATA_W-1:0] fault_addr;
   logic [NUM_CAUSES-1:0] raw, mask, masked, evt;

   assign dir_we   = reg_wr && (reg_addr == ADDR_W'(OFF_DIR));
   assign cmd_we   = reg_wr && (reg_addr == ADDR_W'(OFF_CMD));
   assign zline_we = reg_wr && (reg_addr == ADDR_W'(OFF_ZLINE));
   assign gate_we  = reg_wr && (reg_addr == ADDR_W'(OFF_GATE));
   assign clr_we   = reg_wr && (reg_addr == ADDR_W'(OFF_CLR));
   assign mask_we  = reg_wr && (reg_addr == ADDR_W'(OFF_MASK));

   mmu_cmd_core #(.DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_core (
      .clk             (clk),
      .rst_n           (rst_n),
      .dir_we          (dir_we),
      .cmd_we          (cmd_we),
      .zline_we        (zline_we),
      .gate_we         (gate_we),
      .wdata           (reg_wdata),
      .wk_fault        (wk_fault),
      .wk_fault_addr   (wk_fault_addr),
      .wk_fault_write  (wk_fault_write),
      .paging_o        (xl_paging_en),
      .stall_o         (xl_stall),
      .fault_o         (fault),
      .fault_wr_o      (fault_wr),
      .fault_addr_o    (fault_addr),
      .dir_base_o      (xl_dir_base),
      .zap_all_o       (xl_zap_all),
      .zap_line_o      (xl_zap_line),
      .zap_line_addr_o (xl_zap_line_addr),
      .gate_o          (xl_gate_en),
      .flt_evt_o       (flt_evt),
      .hard_rst_o      (hard_rst)
   );

   always_comb begin
      evt            = '0;
      evt[CAUSE_PF]  = flt_evt;
      evt[CAUSE_BUS] = wk_bus_err;
   end

   mmu_irq_unit #(.NC(NUM_CAUSES)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (hard_rst),
      .evt      (evt),
      .clr_we   (clr_we),
      .mask_we  (mask_we),
      .wbits    (reg_wdata[NUM_CAUSES-1:0]),
      .raw_o    (raw),
      .mask_o   (mask),
      .masked_o (masked),
      .irq_o    (irq)
   );

   mmu_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .addr         (reg_addr),
      .dir_base     (xl_dir_base),
      .paging       (xl_paging_en),
      .fault        (fault),
      .stall        (xl_stall),
      .idle         (wk_idle),
      .replay_empty (wk_replay_empty),
      .fault_wr     (fault_wr),
      .fault_addr   (fault_addr),
      .raw          (raw),
      .mask         (mask),
      .masked       (masked),
      .gate         (xl_gate_en),
      .rdata        (reg_rdata)
   );

   assign xl_hold = fault;

   // R10: interrupt line follows the masked view seen by software
   p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFF_MSTAT)) |-> (irq == (reg_rdata != '0)));

   // R3: the two stall status bits are complementary
   p_stall_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFF_STAT)) |-> (reg_rdata[DATA_W-1] != reg_rdata[ST_STALL]));

endmodule

// File: tb/mmu_cmd_ctrl_tb.sv
module mmu_cmd_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        wk_fault, wk_fault_write, wk_bus_err, wk_idle, wk_replay_empty;
   logic [31:0] wk_fault_addr;
   logic        xl_paging_en, xl_stall, xl_hold, xl_zap_all, xl_zap_line, xl_gate_en, irq;
   logic [31:0] xl_zap_line_addr, xl_dir_base;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   mmu_cmd_ctrl #(.DATA_W(32), .ADDR_W(8), .PAGE_SHIFT(12)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .wk_fault(wk_fault), .wk_fault_addr(wk_fault_addr),
      .wk_fault_write(wk_fault_write), .wk_bus_err(wk_bus_err),
      .wk_idle(wk_idle), .wk_replay_empty(wk_replay_empty),
      .xl_paging_en(xl_paging_en), .xl_stall(xl_stall), .xl_hold(xl_hold),
      .xl_zap_all(xl_zap_all), .xl_zap_line(xl_zap_line),
      .xl_zap_line_addr(xl_zap_line_addr), .xl_dir_base(xl_dir_base),
      .xl_gate_en(xl_gate_en), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic        m_pg, m_st, m_flt, m_fwr, m_za, m_zl, m_gate;
   logic [31:0] m_dir, m_fa, m_zla;
   logic [1:0]  m_raw, m_mask;

   function automatic logic [31:0] m_status();
      logic [31:0] s;
      s = 32'h0;
      s[0] = m_pg; s[1] = m_flt; s[2] = m_st; s[3] = wk_idle;
      s[4] = wk_replay_empty; s[5] = m_fwr; s[31] = !m_st;
      return s;
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         8'h00: return m_dir;
         8'h04: return m_status();
         8'h0C: return m_fa;
         8'h14: return {30'h0, m_raw};
         8'h1C: return {30'h0, m_mask};
         8'h20: return {30'h0, m_raw & m_mask};
         8'h24: return {31'h0, m_gate};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string rd_tag(input logic [7:0] a);
      case (a)
         8'h00: return "R1";
         8'h04: return "R11";
         8'h0C: return "R4";
         8'h10: return "R6";
         8'h14: return "R8";
         8'h18: return "R9";
         8'h1C: return "R10";
         8'h20: return "R10";
         default: return "R12";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pg = 0; m_st = 0; m_flt = 0; m_fwr = 0; m_za = 0; m_zl = 0; m_gate = 0;
         m_dir = 0; m_fa = 0; m_zla = 0; m_raw = 0; m_mask = 0;
      end else begin
         logic fevt, hard;
         logic [1:0] clr;
         logic [31:0] d;
         d    = reg_wdata;
         hard = reg_wr && reg_addr == 8'h08 && d[2:0] == 3'd6;
         fevt = wk_fault && m_pg;
         if (hard) begin
            m_pg = 0; m_st = 0; m_flt = 0; m_fwr = 0; m_za = 0; m_zl = 0; m_gate = 0;
            m_dir = 0; m_fa = 0; m_zla = 0; m_raw = 0; m_mask = 0;
         end else begin
            logic o_pg, o_flt;
            o_pg = m_pg; o_flt = m_flt;
            m_za = 0; m_zl = 0;
            clr = 2'b00;
            if (reg_wr) begin
               case (reg_addr)
                  8'h00: m_dir = d & 32'hFFFF_F000;
                  8'h24: m_gate = d[0];
                  8'h10: begin m_zl = 1; m_zla = d & 32'hFFFF_F000; end
                  8'h18: clr = d[1:0];
                  8'h1C: m_mask = d[1:0];
                  8'h08: case (d[2:0])
                     3'd0: m_pg = 1;
                     3'd1: begin m_pg = 0; m_st = 0; end
                     3'd2: if (o_pg && !o_flt) m_st = 1;
                     3'd3: m_st = 0;
                     3'd4: m_za = 1;
                     3'd5: m_flt = 0;
                     default: ;
                  endcase
                  default: ;
               endcase
            end
            if (fevt && !o_flt) begin
               m_flt = 1; m_fa = wk_fault_addr; m_fwr = wk_fault_write;
            end
            m_raw = {wk_bus_err, fevt} | (m_raw & ~clr);
         end
      end
      #5;
      if (rst_n && !done) begin
         chk("R2",  {31'h0, xl_paging_en}, {31'h0, m_pg});
         chk("R3",  {31'h0, xl_stall},     {31'h0, m_st});
         chk("R4",  {31'h0, xl_hold},      {31'h0, m_flt});
         chk("R6",  {31'h0, xl_zap_all},   {31'h0, m_za});
         chk("R6",  {31'h0, xl_zap_line},  {31'h0, m_zl});
         chk("R6",  xl_zap_line_addr,      m_zla);
         chk("R1",  xl_dir_base,           m_dir);
         chk("R12", {31'h0, xl_gate_en},   {31'h0, m_gate});
         chk("R10", {31'h0, irq},          {31'h0, |(m_raw & m_mask)});
         chk(rd_tag(reg_addr), reg_rdata,  m_read(reg_addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #2;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic fault_pulse(input logic [31:0] a, input logic w);
      @(negedge clk);
      wk_fault = 1; wk_fault_addr = a; wk_fault_write = w;
      @(negedge clk);
      wk_fault = 0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
      wk_fault = 0; wk_fault_addr = 0; wk_fault_write = 0; wk_bus_err = 0;
      wk_idle = 1; wk_replay_empty = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;

      rd_chk(8'h04, 32'h8000_0018, "R11");        // reset state
      rd_chk(8'h00, 32'h0, "R7");
      wr(8'h00, 32'hCAFE_BABE);
      rd_chk(8'h00, 32'hCAFE_B000, "R1");
      wr(8'h08, 32'd2);                             // stall with paging off
      rd_chk(8'h04, 32'h8000_0018, "R3");
      wr(8'h08, 32'd0);
      rd_chk(8'h04, 32'h8000_0019, "R2");
      wr(8'h08, 32'd2);
      rd_chk(8'h04, 32'h0000_001D, "R3");
      wr(8'h08, 32'd3);
      rd_chk(8'h04, 32'h8000_0019, "R3");
      fault_pulse(32'h1234_5678, 1'b1);
      rd_chk(8'h04, 32'h8000_003B, "R4");
      rd_chk(8'h0C, 32'h1234_5678, "R4");
      rd_chk(8'h14, 32'h1, "R8");
      fault_pulse(32'h0BAD_F00D, 1'b0);             // second fault ignored
      rd_chk(8'h0C, 32'h1234_5678, "R4");
      wr(8'h08, 32'd2);                             // stall refused during fault
      rd_chk(8'h04, 32'h8000_003B, "R3");
      wr(8'h08, 32'd5);
      rd_chk(8'h04, 32'h8000_0039, "R5");
      wr(8'h08, 32'd1);
      fault_pulse(32'h5555_0000, 1'b0);             // paging off: ignored
      rd_chk(8'h04, 32'h8000_0038, "R4");
      rd_chk(8'h0C, 32'h1234_5678, "R4");
      @(negedge clk); wk_bus_err = 1; @(negedge clk); wk_bus_err = 0;
      rd_chk(8'h14, 32'h3, "R8");
      wr(8'h1C, 32'h2);
      rd_chk(8'h20, 32'h2, "R10");
      chk("R10", {31'h0, irq}, 32'h1);
      wr(8'h1C, 32'h0);
      chk("R10", {31'h0, irq}, 32'h0);
      wr(8'h18, 32'h1);
      rd_chk(8'h14, 32'h2, "R9");
      wr(8'h08, 32'd0);
      @(negedge clk);                               // clear against new event
      reg_wr = 1; reg_addr = 8'h18; reg_wdata = 32'h1;
      wk_fault = 1; wk_fault_addr = 32'h0000_A000; wk_fault_write = 0;
      @(negedge clk);
      reg_wr = 0; wk_fault = 0;
      rd_chk(8'h14, 32'h3, "R9");
      wr(8'h08, 32'd5);
      wr(8'h08, 32'd4);
      chk("R6", {31'h0, xl_zap_all}, 32'h1);
      @(negedge clk);
      chk("R6", {31'h0, xl_zap_all}, 32'h0);
      wr(8'h10, 32'hABCD_E123);
      chk("R6", xl_zap_line_addr, 32'hABCD_E000);
      rd_chk(8'h10, 32'h0, "R6");
      wr(8'h24, 32'h1);
      rd_chk(8'h24, 32'h1, "R12");
      wr(8'h28, 32'hFFFF_FFFF);
      rd_chk(8'h28, 32'h0, "R12");
      wr(8'h08, 32'd7);
      rd_chk(8'h04, 32'h8000_0019, "R12");
      wr(8'h1C, 32'h3);
      wr(8'h08, 32'd6);
      rd_chk(8'h00, 32'h0, "R7");
      rd_chk(8'h04, 32'h8000_0018, "R7");
      rd_chk(8'h14, 32'h0, "R7");
      rd_chk(8'h1C, 32'h0, "R7");
      rd_chk(8'h24, 32'h0, "R7");
      @(negedge clk); wk_idle = 0; wk_replay_empty = 0;
      rd_chk(8'h04, 32'h8000_0000, "R11");

      // random phase, compared against the model each clock
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         begin
            logic [31:0] r;
            r = $urandom;
            reg_wr = r[0] | r[1];
            case (r[5:2])
               4'd0: reg_addr = 8'h00;  4'd1: reg_addr = 8'h04;
               4'd2, 4'd3, 4'd4: reg_addr = 8'h08;
               4'd5: reg_addr = 8'h0C;  4'd6: reg_addr = 8'h10;
               4'd7: reg_addr = 8'h14;  4'd8: reg_addr = 8'h18;
               4'd9: reg_addr = 8'h1C;  4'd10: reg_addr = 8'h20;
               4'd11: reg_addr = 8'h24; 4'd12: reg_addr = 8'h2C;
               default: reg_addr = 8'h04;
            endcase
            reg_wdata = $urandom;
            if (reg_addr == 8'h08 && reg_wdata[2:0] == 3'd6 && r[9:6] != 0)
               reg_wdata[2:0] = 3'd5;
            wk_fault        = (r[13:10] == 0);
            wk_fault_addr   = $urandom;
            wk_fault_write  = r[14];
            wk_bus_err      = (r[19:15] == 0);
            wk_idle         = r[20];
            wk_replay_empty = r[21];
         end
      end
      @(negedge clk);
      reg_wr = 0; wk_fault = 0; wk_bus_err = 0;
      repeat (2) @(negedge clk);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule